// File: doc/BRIEF.md
# PMP Configuration Shadowing Unit

This unit sits between a core's CSR access port and the register file of a RISC-V physical memory protection (PMP) block that has sixteen regions. The register file is reached through four configuration CSRs and sixteen address CSRs. A sixteen-bit input marks each region as shadowed or live. Software writes to a shadowed region's fields go only into private shadow storage. They never change the protection state that is actually enforced, but a later read returns them as if the write had taken effect. Live regions pass straight through to the real PMP registers.

A configuration CSR packs four regions, one per byte. The unit therefore merges each such CSR byte by byte: shadowed bytes come from the shadow register, and live bytes come from the real register in the same access. Reads are combinational from the CSR address. Writes commit on the rising clock edge. The unit also raises the illegal-instruction flag for PMP CSR accesses when PMP support is off, and for odd configuration CSRs in 64-bit mode.

Top module: `pmp_facade_unit`

## Requirements
- R1: Region n belongs to configuration CSR n/4, byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)). Its mask bit `regionMask[n]` selects shadowing for exactly that byte lane and for address CSR n.
- R2: A configuration CSR read (address 0x3A0+k) returns the live value with the shadowed lanes cleared, ORed with the shadow value restricted to the shadowed lanes.
- R3: A configuration CSR write sends the real register its current bytes in the shadowed lanes and the new write data in the live lanes. The shadow register stores the full written value.
- R4: When all four lanes of the addressed configuration CSR are shadowed, `liveCfgRe` and `liveCfgWe` stay low for that access, and the read returns the shadow value.
- R5: For a shadowed region, an address CSR (0x3B0+n) read or write uses only that region's shadow register and `liveAddrWe` stays low. For a live region it reads `liveAddrRdata` and writes through `liveAddrWe`/`liveAddrWdata`.
- R6: With `pmpEnable` low, any access to 0x3A0-0x3A3 or 0x3B0-0x3BF raises `csrIllegal`, returns zero read data and changes no shadow or real register.
- R7: With `mode64` high, configuration CSRs 0x3A1 and 0x3A3 are illegal as in R6. 0x3A0, 0x3A2 and the address CSRs stay legal.
- R8: Reset clears every shadow configuration and shadow address register to zero.
- R9: Addresses outside both PMP ranges give `csrIllegal` low, zero read data and no live strobes.
- R10: A write becomes visible only after the rising clock edge where `csrWe` is high and the access is legal. Before that edge the read still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pmpEnable | input | 1 | PMP support present; low makes every PMP CSR access illegal |
| mode64 | input | 1 | Core runs with 64-bit registers |
| regionMask | input | 16 | One bit per region; high shadows the region |
| csrAddr | input | 12 | CSR address of the current access |
| csrWdata | input | 32 | CSR write data |
| csrWe | input | 1 | CSR write enable |
| csrRdata | output | 32 | CSR read data (combinational) |
| csrIllegal | output | 1 | Illegal-instruction indication |
| liveCfgIdx | output | 2 | Real configuration register index |
| liveCfgRe | output | 1 | Real configuration register is being read |
| liveCfgRdata | input | 32 | Real configuration register contents |
| liveCfgWe | output | 1 | Real configuration register write strobe |
| liveCfgWdata | output | 32 | Merged value for the real configuration register |
| liveAddrIdx | output | 4 | Real address register index |
| liveAddrRdata | input | 32 | Real address register contents |
| liveAddrWe | output | 1 | Real address register write strobe |
| liveAddrWdata | output | 32 | Value for the real address register |

## Verification
Configuration accesses are tried with masks that shadow no lane, two middle lanes, one lane of a different CSR, and all four lanes. Together these separate a lane-merge error from a wrong region-to-lane mapping and from a missing all-shadowed gating of the live strobes. Address CSRs are written for both a shadowed and a live region, and the bench's model of the real register file then shows whether a shadowed write leaked through. The disabled, 64-bit odd-index and out-of-range accesses are each followed by a legal read of the same location, which proves that the rejected write left no trace. A read sampled just before the write's clock edge, and a reset in the middle of the run, pin down when state changes.

// File: rtl/pmp_facade_pkg.sv
package pmp_facade_pkg;
  localparam int XLEN       = 32;
  localparam int NREG       = 16;
  localparam int LANES      = 4;
  localparam int CFG_CNT    = NREG / LANES;
  localparam int CFG_IDX_W  = $clog2(CFG_CNT);
  localparam int ADDR_IDX_W = $clog2(NREG);
  localparam int LANE_W     = $clog2(LANES);
  localparam int CSR_AW     = 12;
  localparam logic [CSR_AW-1:0] CFG_BASE  = 12'h3A0;
  localparam logic [CSR_AW-1:0] ADDR_BASE = 12'h3B0;

  typedef struct packed {
    logic                  cfgSel;      // legal config CSR access
    logic                  addrSel;     // legal address CSR access
    logic                  illegal;
    logic [CFG_IDX_W-1:0]  cfgIdx;
    logic [ADDR_IDX_W-1:0] addrIdx;
    logic [LANES-1:0]      laneMask;    // shadowed lanes of the config CSR
    logic                  allMasked;
    logic                  addrFacade;  // addressed region is shadowed
    logic                  cfgCommit;
    logic                  addrCommit;
  } strobe_t;
endpackage

// File: rtl/pmp_facade_ctrl.sv
module pmp_facade_ctrl
  import pmp_facade_pkg::*;
(
  input  logic              pmpEnable,
  input  logic              mode64,
  input  logic [NREG-1:0]   regionMask,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic              csrWe,
  output strobe_t           strobe
);
  logic [CSR_AW-1:0]     cfgOff, addrOff;
  logic                  cfgHit, addrHit, badMode, illegal;
  logic [CFG_IDX_W-1:0]  cfgIdx;
  logic [ADDR_IDX_W-1:0] addrIdx;
  logic [LANES-1:0]      laneMask;

  assign cfgOff  = csrAddr - CFG_BASE;
  assign addrOff = csrAddr - ADDR_BASE;
  assign cfgHit  = (csrAddr >= CFG_BASE)  && (cfgOff  < CSR_AW'(CFG_CNT));
  assign addrHit = (csrAddr >= ADDR_BASE) && (addrOff < CSR_AW'(NREG));
  assign cfgIdx  = cfgOff[CFG_IDX_W-1:0];
  assign addrIdx = addrOff[ADDR_IDX_W-1:0];

  // region n sits in config CSR n/LANES, lane n%LANES
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneMask[g] = regionMask[{cfgIdx, LANE_W'(g)}];
  end

  assign badMode = mode64 && cfgIdx[0];
  assign illegal = (cfgHit || addrHit) && (!pmpEnable || (cfgHit && badMode));

  always_comb begin
    strobe            = '0;
    strobe.illegal    = illegal;
    strobe.cfgSel     = cfgHit && !illegal;
    strobe.addrSel    = addrHit && !illegal;
    strobe.cfgIdx     = cfgIdx;
    strobe.addrIdx    = addrIdx;
    strobe.laneMask   = laneMask;
    strobe.allMasked  = &laneMask;
    strobe.addrFacade = regionMask[addrIdx];
    strobe.cfgCommit  = csrWe && cfgHit && !illegal;
    strobe.addrCommit = csrWe && addrHit && !illegal;
  end
endmodule

// File: rtl/pmp_facade_dp.sv
module pmp_facade_dp
  import pmp_facade_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [XLEN-1:0]       csrWdata,
  output logic [XLEN-1:0]       csrRdata,
  output logic [CFG_IDX_W-1:0]  liveCfgIdx,
  output logic                  liveCfgRe,
  input  logic [XLEN-1:0]       liveCfgRdata,
  output logic                  liveCfgWe,
  output logic [XLEN-1:0]       liveCfgWdata,
  output logic [ADDR_IDX_W-1:0] liveAddrIdx,
  input  logic [XLEN-1:0]       liveAddrRdata,
  output logic                  liveAddrWe,
  output logic [XLEN-1:0]       liveAddrWdata
);
  localparam int LANE_BITS = XLEN / LANES;

  logic [XLEN-1:0] shadowCfg  [CFG_CNT];
  logic [XLEN-1:0] shadowAddr [NREG];
  logic [XLEN-1:0] byteMask, liveView, cfgView;

  for (genvar g = 0; g < LANES; g++) begin : gMask
    assign byteMask[g*LANE_BITS +: LANE_BITS] = {LANE_BITS{strobe.laneMask[g]}};
  end

  // live register is not touched when every lane is shadowed
  assign liveView = strobe.allMasked ? '0 : (liveCfgRdata & ~byteMask);
  assign cfgView  = liveView | (shadowCfg[strobe.cfgIdx] & byteMask);

  always_comb begin
    if (strobe.cfgSel)       csrRdata = cfgView;
    else if (strobe.addrSel) csrRdata = strobe.addrFacade ? shadowAddr[strobe.addrIdx]
                                                          : liveAddrRdata;
    else                     csrRdata = '0;
  end

  assign liveCfgIdx    = strobe.cfgIdx;
  assign liveCfgRe     = strobe.cfgSel && !strobe.allMasked;
  assign liveCfgWe     = strobe.cfgCommit && !strobe.allMasked;
  assign liveCfgWdata  = (liveCfgRdata & byteMask) | (csrWdata & ~byteMask);
  assign liveAddrIdx   = strobe.addrIdx;
  assign liveAddrWe    = strobe.addrCommit && !strobe.addrFacade;
  assign liveAddrWdata = csrWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_CNT; i++) shadowCfg[i] <= '0;
      for (int i = 0; i < NREG; i++)    shadowAddr[i] <= '0;
    end else begin
      if (strobe.cfgCommit) shadowCfg[strobe.cfgIdx] <= csrWdata;
      if (strobe.addrCommit && strobe.addrFacade) shadowAddr[strobe.addrIdx] <= csrWdata;
    end
  end
endmodule

// File: rtl/pmp_facade_unit.sv
module pmp_facade_unit
  import pmp_facade_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pmpEnable,
  input  logic                  mode64,
  input  logic [NREG-1:0]       regionMask,
  input  logic [CSR_AW-1:0]     csrAddr,
  input  logic [XLEN-1:0]       csrWdata,
  input  logic                  csrWe,
  output logic [XLEN-1:0]       csrRdata,
  output logic                  csrIllegal,
  output logic [CFG_IDX_W-1:0]  liveCfgIdx,
  output logic                  liveCfgRe,
  input  logic [XLEN-1:0]       liveCfgRdata,
  output logic                  liveCfgWe,
  output logic [XLEN-1:0]       liveCfgWdata,
  output logic [ADDR_IDX_W-1:0] liveAddrIdx,
  input  logic [XLEN-1:0]       liveAddrRdata,
  output logic                  liveAddrWe,
  output logic [XLEN-1:0]       liveAddrWdata
);
  strobe_t strobe;

  pmp_facade_ctrl u_ctrl (
    .pmpEnable (pmpEnable),
    .mode64    (mode64),
    .regionMask(regionMask),
    .csrAddr   (csrAddr),
    .csrWe     (csrWe),
    .strobe    (strobe)
  );

  pmp_facade_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .csrWdata     (csrWdata),
    .csrRdata     (csrRdata),
    .liveCfgIdx   (liveCfgIdx),
    .liveCfgRe    (liveCfgRe),
    .liveCfgRdata (liveCfgRdata),
    .liveCfgWe    (liveCfgWe),
    .liveCfgWdata (liveCfgWdata),
    .liveAddrIdx  (liveAddrIdx),
    .liveAddrRdata(liveAddrRdata),
    .liveAddrWe   (liveAddrWe),
    .liveAddrWdata(liveAddrWdata)
  );

  assign csrIllegal = strobe.illegal;
endmodule

// File: rtl/pmp_facade_chk.sv
module pmp_facade_chk
  import pmp_facade_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  pmpEnable,
  input logic                  mode64,
  input logic [NREG-1:0]       regionMask,
  input logic [CSR_AW-1:0]     csrAddr,
  input logic [XLEN-1:0]       csrWdata,
  input logic                  csrWe,
  input logic [XLEN-1:0]       csrRdata,
  input logic                  csrIllegal,
  input logic [CFG_IDX_W-1:0]  liveCfgIdx,
  input logic                  liveCfgRe,
  input logic [XLEN-1:0]       liveCfgRdata,
  input logic                  liveCfgWe,
  input logic [XLEN-1:0]       liveCfgWdata,
  input logic [ADDR_IDX_W-1:0] liveAddrIdx,
  input logic [XLEN-1:0]       liveAddrRdata,
  input logic                  liveAddrWe,
  input logic [XLEN-1:0]       liveAddrWdata
);
  logic cfgRange, addrRange, cfgFullMask;
  logic [1:0] cIdx;
  logic [3:0] aIdx;

  assign cfgRange    = (csrAddr[11:2] == 10'b0011_1010_00);
  assign addrRange   = (csrAddr[11:4] == 8'h3B);
  assign cIdx        = csrAddr[1:0];
  assign aIdx        = csrAddr[3:0];
  assign cfgFullMask = (regionMask[cIdx*4 +: 4] == 4'hF);

  a_r4_no_live_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRange && cfgFullMask) |-> (!liveCfgRe && !liveCfgWe));

  a_r5_no_live_addr_write: assert property (@(posedge clk) disable iff (!rstN)
    (addrRange && regionMask[aIdx]) |-> !liveAddrWe);

  a_r6_disabled_illegal: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgRange || addrRange) && !pmpEnable) |-> (csrIllegal && csrRdata == '0));

  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (!liveCfgWe && !liveAddrWe));

  a_r7_odd_cfg_64: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRange && mode64 && cIdx[0]) |-> csrIllegal);

  a_r9_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRange && !addrRange) |-> (!csrIllegal && csrRdata == '0 && !liveCfgWe && !liveAddrWe));

  a_r10_shadow_readback: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && !csrIllegal && addrRange && regionMask[aIdx]) |=>
      (!($stable(csrAddr) && $stable(regionMask) && pmpEnable) || csrRdata == $past(csrWdata)));
endmodule

bind pmp_facade_unit pmp_facade_chk u_chk (.*);

// File: tb/pmp_facade_unit_tb.sv
module pmp_facade_unit_tb;
  import pmp_facade_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pmpEnable = 1'b1, mode64 = 1'b0, csrWe = 1'b0;
  logic [NREG-1:0] regionMask = '0;
  logic [CSR_AW-1:0] csrAddr = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata, liveCfgRdata, liveCfgWdata, liveAddrRdata, liveAddrWdata;
  logic csrIllegal, liveCfgRe, liveCfgWe, liveAddrWe;
  logic [CFG_IDX_W-1:0] liveCfgIdx;
  logic [ADDR_IDX_W-1:0] liveAddrIdx;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // model of the real PMP register file
  logic [XLEN-1:0] realCfg [CFG_CNT];
  logic [XLEN-1:0] realAddr [NREG];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_CNT; i++) realCfg[i] <= '0;
      realCfg[0] <= 32'h0F0E0D0C;
      for (int i = 0; i < NREG; i++) realAddr[i] <= '0;
    end else begin
      if (liveCfgWe)  realCfg[liveCfgIdx]   <= liveCfgWdata;
      if (liveAddrWe) realAddr[liveAddrIdx] <= liveAddrWdata;
    end
  end
  assign liveCfgRdata  = realCfg[liveCfgIdx];
  assign liveAddrRdata = realAddr[liveAddrIdx];

  pmp_facade_unit u_dut (.*);

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        we;
    logic        en;
    logic        m64;
    logic [15:0] mask;
    logic [31:0] expRd;
    logic        expIll;
    logic        chkRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{12'h3A0, 32'h0,        0, 1, 0, 16'h0006, 32'h0F00000C, 0, 1, 8'd2},  // R2 merge
    '{12'h3A0, 32'hAABBCCDD, 1, 1, 0, 16'h0006, 32'h0,        0, 0, 8'd3},  // R3 write
    '{12'h3A0, 32'h0,        0, 1, 0, 16'h0006, 32'hAABBCCDD, 0, 1, 8'd2},
    '{12'h3B1, 32'h12345678, 1, 1, 0, 16'h0006, 32'h0,        0, 0, 8'd5},  // R5 shadowed
    '{12'h3B1, 32'h0,        0, 1, 0, 16'h0006, 32'h12345678, 0, 1, 8'd5},
    '{12'h3B3, 32'hCAFE0003, 1, 1, 0, 16'h0006, 32'h0,        0, 0, 8'd5},  // R5 live
    '{12'h3B3, 32'h0,        0, 1, 0, 16'h0006, 32'hCAFE0003, 0, 1, 8'd5},
    '{12'h3A3, 32'h55667788, 1, 1, 0, 16'hF000, 32'h0,        0, 0, 8'd4},  // R4 all lanes
    '{12'h3A3, 32'h0,        0, 1, 0, 16'hF000, 32'h55667788, 0, 1, 8'd4},
    '{12'h3A1, 32'h0,        0, 0, 0, 16'h0006, 32'h0,        1, 1, 8'd6},  // R6 disabled
    '{12'h3B5, 32'h0000DEAD, 1, 0, 0, 16'h0020, 32'h0,        1, 1, 8'd6},
    '{12'h3B5, 32'h0,        0, 1, 0, 16'h0020, 32'h0,        0, 1, 8'd6},
    '{12'h3A1, 32'h0,        0, 1, 1, 16'h0000, 32'h0,        1, 1, 8'd7},  // R7 odd 64
    '{12'h3A2, 32'h0,        0, 1, 1, 16'h0000, 32'h0,        0, 1, 8'd7},
    '{12'h3A1, 32'h11223344, 1, 1, 1, 16'h0000, 32'h0,        1, 1, 8'd7},
    '{12'h3A1, 32'h0,        0, 1, 0, 16'h0000, 32'h0,        0, 1, 8'd7},
    '{12'h300, 32'h0,        0, 1, 0, 16'hFFFF, 32'h0,        0, 1, 8'd9},  // R9 outside
    '{12'h3A1, 32'h44332211, 1, 1, 0, 16'h0020, 32'h0,        0, 0, 8'd1},  // R1 region 5
    '{12'h3A1, 32'h0,        0, 1, 0, 16'h0020, 32'h44332211, 0, 1, 8'd1},
    '{12'h3A1, 32'h0,        0, 1, 0, 16'h0000, 32'h44330011, 0, 1, 8'd1}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [31:0] d, input logic w,
                       input logic [15:0] m);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = w; regionMask = m;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R8: shadows start at zero; R4: all-shadowed read keeps the live port idle
    drive(12'h3A0, 32'h0, 1'b0, 16'hFFFF);
    check("R8", "shadow cfg after reset", csrRdata, 32'h0);
    check("R4", "liveCfgRe all shadowed", {31'b0, liveCfgRe}, 32'h0);
    drive(12'h3B0, 32'h0, 1'b0, 16'hFFFF);
    check("R8", "shadow addr after reset", csrRdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      csrAddr = VEC[i].addr; csrWdata = VEC[i].wdata; csrWe = VEC[i].we;
      pmpEnable = VEC[i].en; mode64 = VEC[i].m64; regionMask = VEC[i].mask;
      #1;
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d illegal", i),
            {31'b0, csrIllegal}, {31'b0, VEC[i].expIll});
      if (VEC[i].chkRd)
        check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rdata", i), csrRdata, VEC[i].expRd);
    end
    drive(12'h300, 32'h0, 1'b0, 16'h0);
    pmpEnable = 1'b1; mode64 = 1'b0;

    // real register file contents after the table
    check("R3", "real cfg0 merged", realCfg[0], 32'hAA0E0DDD);
    check("R5", "real addr1 untouched", realAddr[1], 32'h0);
    check("R5", "real addr3 written", realAddr[3], 32'hCAFE0003);
    check("R4", "real cfg3 untouched", realCfg[3], 32'h0);
    check("R6", "real addr5 untouched", realAddr[5], 32'h0);
    check("R7", "real cfg1 lane merge", realCfg[1], 32'h44330011);

    // R4: live read strobe appears once any lane is live
    drive(12'h3A3, 32'h0, 1'b0, 16'h7000);
    check("R4", "liveCfgRe partly shadowed", {31'b0, liveCfgRe}, 32'h1);
    drive(12'h3A3, 32'h0, 1'b0, 16'hF000);
    check("R4", "liveCfgRe fully shadowed", {31'b0, liveCfgRe}, 32'h0);

    // R10: write is not visible before its edge, visible after
    drive(12'h3B2, 32'hBEEF0002, 1'b1, 16'h0004);
    check("R10", "before edge", csrRdata, 32'h0);
    @(posedge clk); #1;
    csrWe = 1'b0;
    #1;
    check("R10", "after edge", csrRdata, 32'hBEEF0002);

    // R8: reset in mid-run clears shadows
    drive(12'h3A3, 32'h0, 1'b0, 16'hF000);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R8", "shadow cleared by reset", csrRdata, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule